// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Feedback Divider

This block is the digital divider section of a frequency synthesizer. On the fast input clock it runs a prescaler that divides by P+1 or by P. The prescaler's output steps two down-counters together. The swallow counter holds the prescaler at P+1 until it reaches zero, and then P applies. The main counter marks the end of a division cycle when it times out. At that point both counters reload, and one output pulse is issued. The total division ratio is N = B·P + A.

A second, independent section runs on the reference clock. It divides that clock by R and produces the comparison-rate pulse that the phase detector outside this block compares against the divided output.

Programming uses one load strobe in each clock domain. A setting that is accepted is staged and takes over only at the end of the current division cycle. A rejected setting raises an error flag, and the settings already in use stay in force.

Top module: `dmfd_divider`

## Requirements
- R1: With ratio settings P, A and B in force, consecutive `div_out` pulses are exactly B·P + A `vco_clk` cycles apart.
- R2: `div_out` is high for one `vco_clk` cycle only: the cycle in which the main counter times out.
- R3: The ratio holds at the boundaries of the swallow count. A = 0 gives B·P, and A = B−1 gives B·P + B−1.
- R4: P, A and B values loaded with `cfg_load` do not change the division cycle in progress. The next full cycle uses the new values.
- R5: A load with B ≤ A or P < 2 sets `cfg_err` one `vco_clk` edge after the load. The spacing between `div_out` pulses stays at the previous ratio.
- R6: A valid load clears `cfg_err` one `vco_clk` edge after the load.
- R7: With R in force, consecutive `ref_out` pulses are exactly R `ref_clk` cycles apart. R = 1 holds `ref_out` high on every cycle.
- R8: A new R loaded with `ref_load` takes effect after the reference period in progress. A load with R = 0 sets `ref_err` one `ref_clk` edge later, and the old R is kept. A valid R load clears `ref_err`.
- R9: After reset, the defaults are P=8, A=3, B=5 (N = 43) and R = 10, with `div_out`, `ref_out`, `cfg_err` and `ref_err` all low. The first `div_out` pulse arrives N−1 `vco_clk` edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast input clock being divided |
| ref_clk | input | 1 | Reference clock for the R divider |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_load | input | 1 | Strobe in the vco_clk domain that stages P, A and B |
| cfg_p | input | 6 | Prescaler base modulus P |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 10 | Main count B |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | The last P/A/B load was rejected |
| ref_load | input | 1 | Strobe in the ref_clk domain that stages R |
| cfg_r | input | 12 | Reference division ratio R |
| ref_out | output | 1 | One-cycle pulse per R reference cycles |
| ref_err | output | 1 | The last R load was rejected |

## Verification
Both error flags are registered, so each one is due on the clock edge right after its load strobe. The bench reads them at the falling edge that follows. A staged ratio is seen only in the second pulse interval after the load, because the interval in progress must still measure the old ratio. The bench loads one falling edge after a pulse and measures both intervals. Intervals are counted in falling edges from one output pulse to the next. The first pulse after reset is due N−1 rising edges after release, because the counters start from their reset state.

// File: rtl/dmfd_pkg.sv
package dmfd_pkg;
    typedef enum logic {
        MOD_BASE = 1'b0,
        MOD_PLUS = 1'b1
    } modulus_e;
endpackage

// File: rtl/dmfd_prescaler.sv
module dmfd_prescaler
    import dmfd_pkg::*;
#(
    parameter int P_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] p_val,
    input  modulus_e       modsel,
    output logic           tick
);
    typedef struct packed {
        logic [P_W-1:0] cnt;
    } pre_t;

    pre_t           st_q, st_d;
    logic [P_W-1:0] last_cnt;

    always_comb begin
        st_d     = st_q;
        last_cnt = (modsel == MOD_PLUS) ? p_val : (p_val - P_W'(1));
        tick     = (st_q.cnt == last_cnt);
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + P_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= p_val);
endmodule

// File: rtl/dmfd_swallow.sv
module dmfd_swallow
    import dmfd_pkg::*;
#(
    parameter int A_W   = 6,
    parameter int B_W   = 10,
    parameter int DEF_A = 3,
    parameter int DEF_B = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [A_W-1:0] a_preset,
    input  logic [B_W-1:0] b_preset,
    output modulus_e       modsel,
    output logic           terminal
);
    typedef struct packed {
        logic [A_W-1:0] a_cnt;
        logic [B_W-1:0] b_cnt;
    } sw_t;

    sw_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        modsel   = (st_q.a_cnt != '0) ? MOD_PLUS : MOD_BASE;
        terminal = tick && (st_q.b_cnt == B_W'(1));
        if (terminal) begin
            st_d.a_cnt = a_preset;
            st_d.b_cnt = b_preset;
        end else if (tick) begin
            st_d.b_cnt = st_q.b_cnt - B_W'(1);
            if (st_q.a_cnt != '0) begin
                st_d.a_cnt = st_q.a_cnt - A_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.a_cnt <= A_W'(DEF_A);
            st_q.b_cnt <= B_W'(DEF_B);
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    a_below_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        B_W'(st_q.a_cnt) < st_q.b_cnt);

    // R3
    plus_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !terminal && st_q.a_cnt == A_W'(1)) |=> (modsel == MOD_BASE));
endmodule

// File: rtl/dmfd_cfg.sv
module dmfd_cfg #(
    parameter int P_W   = 6,
    parameter int A_W   = 6,
    parameter int B_W   = 10,
    parameter int DEF_P = 8,
    parameter int DEF_A = 3,
    parameter int DEF_B = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [P_W-1:0] new_p,
    input  logic [A_W-1:0] new_a,
    input  logic [B_W-1:0] new_b,
    input  logic           terminal,
    output logic [P_W-1:0] act_p,
    output logic [A_W-1:0] nxt_a,
    output logic [B_W-1:0] nxt_b,
    output logic           err
);
    typedef struct packed {
        logic [P_W-1:0] act_p;
        logic [A_W-1:0] act_a;
        logic [B_W-1:0] act_b;
        logic [P_W-1:0] pen_p;
        logic [A_W-1:0] pen_a;
        logic [B_W-1:0] pen_b;
        logic           pen_v;
        logic           err;
    } cfg_t;

    cfg_t st_q, st_d;
    logic good;

    always_comb begin
        st_d = st_q;
        good = (new_p >= P_W'(2)) && (B_W'(new_a) < new_b);
        if (terminal && st_q.pen_v) begin
            st_d.act_p = st_q.pen_p;
            st_d.act_a = st_q.pen_a;
            st_d.act_b = st_q.pen_b;
            st_d.pen_v = 1'b0;
        end
        if (load) begin
            if (good) begin
                st_d.pen_p = new_p;
                st_d.pen_a = new_a;
                st_d.pen_b = new_b;
                st_d.pen_v = 1'b1;
                st_d.err   = 1'b0;
            end else begin
                st_d.err   = 1'b1;
            end
        end
    end

    assign act_p = st_q.act_p;
    assign nxt_a = st_q.pen_v ? st_q.pen_a : st_q.act_a;
    assign nxt_b = st_q.pen_v ? st_q.pen_b : st_q.act_b;
    assign err   = st_q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.act_p <= P_W'(DEF_P);
            st_q.act_a <= A_W'(DEF_A);
            st_q.act_b <= B_W'(DEF_B);
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    active_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act_p >= P_W'(2)) && (B_W'(st_q.act_a) < st_q.act_b));

    // R4
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !terminal |=> ($stable(st_q.act_p) && $stable(st_q.act_a) && $stable(st_q.act_b)));

    // R5
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ((new_p < P_W'(2)) || (B_W'(new_a) >= new_b))) |=> err);
endmodule

// File: rtl/dmfd_refdiv.sv
module dmfd_refdiv #(
    parameter int R_W   = 12,
    parameter int DEF_R = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [R_W-1:0] new_r,
    output logic           pulse,
    output logic           err
);
    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic [R_W-1:0] act_r;
        logic [R_W-1:0] pen_r;
        logic           pen_v;
        logic           err;
    } ref_t;

    ref_t st_q, st_d;
    logic term;

    always_comb begin
        st_d = st_q;
        term = (st_q.cnt == (st_q.act_r - R_W'(1)));
        if (term) begin
            st_d.cnt = '0;
            if (st_q.pen_v) begin
                st_d.act_r = st_q.pen_r;
                st_d.pen_v = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + R_W'(1);
        end
        if (load) begin
            if (new_r != '0) begin
                st_d.pen_r = new_r;
                st_d.pen_v = 1'b1;
                st_d.err   = 1'b0;
            end else begin
                st_d.err   = 1'b1;
            end
        end
    end

    assign pulse = term;
    assign err   = st_q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.act_r <= R_W'(DEF_R);
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    ref_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.act_r);

    // R8
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> $stable(st_q.act_r));

    // R8
    ref_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && new_r == '0) |=> err);
endmodule

// File: rtl/dmfd_divider.sv
module dmfd_divider
    import dmfd_pkg::*;
#(
    parameter int P_W   = 6,
    parameter int A_W   = 6,
    parameter int B_W   = 10,
    parameter int R_W   = 12,
    parameter int DEF_P = 8,
    parameter int DEF_A = 3,
    parameter int DEF_B = 5,
    parameter int DEF_R = 10
) (
    input  logic           vco_clk,
    input  logic           ref_clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [P_W-1:0] cfg_p,
    input  logic [A_W-1:0] cfg_a,
    input  logic [B_W-1:0] cfg_b,
    output logic           div_out,
    output logic           cfg_err,
    input  logic           ref_load,
    input  logic [R_W-1:0] cfg_r,
    output logic           ref_out,
    output logic           ref_err
);
    logic           presc_tick;
    logic           b_done;
    modulus_e       modsel;
    logic [P_W-1:0] act_p;
    logic [A_W-1:0] nxt_a;
    logic [B_W-1:0] nxt_b;

    dmfd_cfg #(
        .P_W(P_W), .A_W(A_W), .B_W(B_W),
        .DEF_P(DEF_P), .DEF_A(DEF_A), .DEF_B(DEF_B)
    ) u_cfg (
        .clk(vco_clk), .rst_n(rst_n), .load(cfg_load),
        .new_p(cfg_p), .new_a(cfg_a), .new_b(cfg_b),
        .terminal(b_done), .act_p(act_p), .nxt_a(nxt_a), .nxt_b(nxt_b),
        .err(cfg_err)
    );

    dmfd_prescaler #(.P_W(P_W)) u_presc (
        .clk(vco_clk), .rst_n(rst_n), .p_val(act_p), .modsel(modsel),
        .tick(presc_tick)
    );

    dmfd_swallow #(
        .A_W(A_W), .B_W(B_W), .DEF_A(DEF_A), .DEF_B(DEF_B)
    ) u_swallow (
        .clk(vco_clk), .rst_n(rst_n), .tick(presc_tick),
        .a_preset(nxt_a), .b_preset(nxt_b), .modsel(modsel),
        .terminal(b_done)
    );

    dmfd_refdiv #(.R_W(R_W), .DEF_R(DEF_R)) u_ref (
        .clk(ref_clk), .rst_n(rst_n), .load(ref_load), .new_r(cfg_r),
        .pulse(ref_out), .err(ref_err)
    );

    assign div_out = b_done;

    // R2
    single_pulse_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
        div_out |=> !div_out);
endmodule

// File: tb/dmfd_divider_test.sv
module dmfd_divider_test;
    logic        vco_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        cfg_load = 1'b0;
    logic [5:0]  cfg_p = '0;
    logic [5:0]  cfg_a = '0;
    logic [9:0]  cfg_b = '0;
    logic        ref_load = 1'b0;
    logic [11:0] cfg_r = '0;
    logic        div_out, cfg_err, ref_out, ref_err;

    int checks   = 0;
    int failures = 0;

    always #4  vco_clk = ~vco_clk;
    always #10 ref_clk = ~ref_clk;

    dmfd_divider uut (
        .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .cfg_load(cfg_load), .cfg_p(cfg_p), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .div_out(div_out), .cfg_err(cfg_err),
        .ref_load(ref_load), .cfg_r(cfg_r), .ref_out(ref_out), .ref_err(ref_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts falling edges until the next div_out pulse
    task automatic vco_gap(inout int n);
        do begin
            @(negedge vco_clk);
            n++;
        end while (!div_out && n < 5000);
    endtask

    task automatic ref_gap(inout int n);
        do begin
            @(negedge ref_clk);
            n++;
        end while (!ref_out && n < 5000);
    endtask

    // load P/A/B one edge after a pulse; old ratio, then new ratio
    task automatic vco_program(input string req, input int p, input int a, input int b,
                               input int old_n, input int new_n, input int exp_err);
        int n = 0;
        vco_gap(n);
        n = 0;
        @(negedge vco_clk); n++;
        cfg_p = 6'(p); cfg_a = 6'(a); cfg_b = 10'(b); cfg_load = 1'b1;
        @(negedge vco_clk); n++;
        cfg_load = 1'b0;
        chk({req, " err flag"}, int'(cfg_err), exp_err);
        vco_gap(n);
        chk({req, " cycle in progress"}, n, old_n);
        n = 0;
        vco_gap(n);
        chk({req, " following cycle"}, n, new_n);
    endtask

    task automatic ref_program(input string req, input int r, input int old_r,
                               input int new_r, input int exp_err);
        int n = 0;
        ref_gap(n);
        n = 0;
        @(negedge ref_clk); n++;
        cfg_r = 12'(r); ref_load = 1'b1;
        @(negedge ref_clk); n++;
        ref_load = 1'b0;
        chk({req, " ref err flag"}, int'(ref_err), exp_err);
        if (n < old_r) ref_gap(n);
        chk({req, " ref period in progress"}, n, old_r);
        n = 0;
        ref_gap(n);
        chk({req, " ref following period"}, n, new_r);
    endtask

    task automatic test_reset();
        int n = 0;
        repeat (3) @(negedge vco_clk);
        rst_n = 1'b1;
        chk("R9 div_out at reset", int'(div_out), 0);
        chk("R9 cfg_err at reset", int'(cfg_err), 0);
        chk("R9 ref_out at reset", int'(ref_out), 0);
        chk("R9 ref_err at reset", int'(ref_err), 0);
        vco_gap(n);
        chk("R9 first pulse edge count", n, 42);
    endtask

    task automatic test_default_ratio();
        int n = 0;
        vco_gap(n);
        chk("R1 default period", n, 43);
        n = 0;
        @(negedge vco_clk); n++;
        chk("R2 pulse width one cycle", int'(div_out), 0);
        vco_gap(n);
        chk("R1 default period again", n, 43);
    endtask

    task automatic test_vco_modes();
        vco_program("R4 P=4 A=2 B=7", 4, 2, 7, 43, 30, 0);
        vco_program("R3 A=0 P=5 B=9", 5, 0, 9, 30, 45, 0);
        vco_program("R3 A=B-1 P=3 B=9", 3, 8, 9, 45, 35, 0);
    endtask

    task automatic test_rejects();
        vco_program("R5 B equal A", 6, 5, 5, 35, 35, 1);
        vco_program("R5 P below 2", 1, 1, 4, 35, 35, 1);
        vco_program("R6 valid load clears", 2, 1, 10, 35, 21, 0);
    endtask

    task automatic test_reference();
        int n = 0;
        ref_gap(n);
        n = 0;
        ref_gap(n);
        chk("R7 default ref period", n, 10);
        ref_program("R8 R=3", 3, 10, 3, 0);
        ref_program("R8 R=0 rejected", 0, 3, 3, 1);
        ref_program("R7 R=1 boundary", 1, 3, 1, 0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        test_reset();
        test_default_ratio();
        test_vco_modes();
        test_rejects();
        test_reference();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule